// File: doc/BRIEF.md
# Dual-Seed CRC16 Generator and Checker

This block computes a 16-bit cyclic redundancy check over a stream of packet bytes. It serves both directions of a link. Bytes arrive one per clock on a valid-qualified stream, with a start strobe on the first byte and an end strobe on the last. The first byte is normally the length byte. The direction and, for transmit, the seed choice are taken from the inputs on the start byte and then held for the rest of the packet.

On transmit, every byte is passed to the output one cycle later. Two CRC bytes are then appended, low byte first. They are computed either from the programmed seed or from a zero seed, as a select input chooses.

On receive, the last two bytes of the packet are the CRC field. Two engines run side by side, one loaded with the programmed seed and one with zero. One cycle after the end strobe, the block reports whether the field matched each seed, together with the OR of the two results.

Top module: `crc16_dualseed`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o`, `res_valid_o`, `crc_ok_seed_o`, `crc_ok_zero_o` and `crc_ok_o` are all 0.
- R2: The CRC uses the polynomial x^16+x^15+x^2+1 in reflected form (constant 0xA001). Data bits are taken least significant bit first, with no final inversion, and the engines advance by one accepted byte per clock. With `tx_zero_seed_i`=0 on the start byte, the appended CRC is computed from `seed_i` as sampled on that byte.
- R3: With `tx_zero_seed_i`=1 on the start byte, the appended CRC is computed from the seed 0x0000.
- R4: In transmit mode, each accepted byte appears on `out_data_o`, with `out_valid_o`=1 and `out_crc_o`=0, exactly one cycle after it is accepted. The two appended bytes carry `out_crc_o`=1. The second appended byte is the only one that carries `out_last_o`=1.
- R5: The low CRC byte is output in the cycle right after the last packet byte, and the high CRC byte follows in the next cycle. Input bytes presented during those two append cycles are discarded.
- R6: In receive mode, `res_valid_o` pulses for one cycle, one cycle after the accepted end byte. `crc_ok_seed_o`=1 exactly when the last two bytes (low byte first) equal the CRC of all earlier packet bytes computed from `seed_i`.
- R7: `crc_ok_zero_o`=1 exactly when the received field equals the CRC of the earlier bytes computed from seed 0. `crc_ok_o` is the OR of `crc_ok_seed_o` and `crc_ok_zero_o`.
- R8: A start strobe on an accepted byte reloads both engines, even if a packet is still in progress. The earlier partial packet then has no effect on any result.
- R9: A byte is ignored when `in_valid_o` is low, regardless of its start and end strobes. A byte is also ignored when it arrives outside a packet without a start strobe.
- R10: The three result flags hold their values until the next receive end byte. Transmit packets do not change them.
- R11: `out_valid_o` is never 1 for a receive packet, and `res_valid_o` is never 1 for a transmit packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_i | input | 16 | Programmed CRC seed, sampled on the start byte |
| dir_tx_i | input | 1 | 1 = transmit packet, 0 = receive packet, sampled on the start byte |
| tx_zero_seed_i | input | 1 | Transmit: 1 = append the CRC computed from zero seed, sampled on the start byte |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Marks the first byte of a packet |
| in_eop_i | input | 1 | Marks the last byte of a packet |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Transmit output byte valid |
| out_data_o | output | 8 | Transmit output byte |
| out_crc_o | output | 1 | Output byte is an appended CRC byte |
| out_last_o | output | 1 | Output byte is the last byte of the packet |
| res_valid_o | output | 1 | Receive check result strobe |
| crc_ok_seed_o | output | 1 | Field matched the CRC computed from the programmed seed |
| crc_ok_zero_o | output | 1 | Field matched the CRC computed from the zero seed |
| crc_ok_o | output | 1 | Field matched under either seed |

## Verification
Some behaviours are checked by the assertions on every cycle:
- Engines hold their state on idle cycles.
- Inputs are gated while CRC bytes are being appended.
- The appended pair follows the last data byte in fixed order.
- A result strobe follows every receive end byte.
- The result flags stay stable between strobes.
- Transmit output and result strobes never coincide.

Other behaviours can only be shown by the bench scenarios, which compare the block against its own CRC model:
- The CRC values themselves.
- Correct seed selection on transmit.
- The match flags for fields built from the seed, from zero or at random.
- Restarting a packet mid-stream.
- Discarding stray, idle and append-time bytes.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W   = 16;
  localparam int BYTE_W  = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

  // One byte step of a reflected CRC, least significant data bit first.
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0]  crc,
    input logic [BYTE_W-1:0] data,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    c = crc;
    for (int b = 0; b < BYTE_W; b++) begin
      if (c[0] ^ data[b]) c = (c >> 1) ^ poly;
      else                c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = POLY_REFL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRC_W-1:0]  init_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] base;

  assign base       = load_i ? init_i : crc_o;
  assign crc_next_o = step_i ? crc_step(base, data_i, POLY) : crc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_o <= '0;
    else        crc_o <= crc_next_o;
  end

  // R9: the state never moves on a cycle without an accepted byte
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(crc_o));
endmodule

// File: rtl/crc16_tx_append.sv
module crc16_tx_append
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              eop_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_crc_o,
  output logic              out_last_o
);
  localparam int NB    = CRC_W / BYTE_W;
  localparam int CNT_W = $clog2(NB + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             start_append;

  assign busy_o       = (cnt_q != '0);
  assign idx          = CNT_W'(NB) - cnt_q;
  assign start_append = acc_i && eop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_crc_o   <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (busy_o) begin
      cnt_q       <= cnt_q - 1'b1;
      out_valid_o <= 1'b1;
      out_data_o  <= BYTE_W'(crc_i >> (int'(idx) * BYTE_W));
      out_crc_o   <= 1'b1;
      out_last_o  <= (cnt_q == CNT_W'(1));
    end else begin
      cnt_q       <= start_append ? CNT_W'(NB) : '0;
      out_valid_o <= acc_i;
      out_data_o  <= acc_i ? data_i : out_data_o;
      out_crc_o   <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end

  // R5: the last data byte is followed by the append phase
  a_r5_append_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_append |=> out_valid_o && !out_crc_o && busy_o);
  // R5: no byte is taken while appending
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !acc_i);
  // R4: last data byte, then a low CRC byte that is not last
  a_r4_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_crc_o && busy_o) |=> out_crc_o && !out_last_o);
  // R4: a non-final CRC byte is followed by the final one
  a_r4_last_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (out_crc_o && !out_last_o) |=> out_crc_o && out_last_o);
endmodule

// File: rtl/crc16_rx_check.sv
module crc16_rx_check
  import crc16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eop_i,
  input  logic [CRC_W-1:0] seed_next_i,
  input  logic [CRC_W-1:0] zero_next_i,
  output logic             res_valid_o,
  output logic             ok_seed_o,
  output logic             ok_zero_o
);
  // The field is appended low byte first, so a match leaves a zero residue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      ok_seed_o   <= 1'b0;
      ok_zero_o   <= 1'b0;
    end else begin
      res_valid_o <= eop_i;
      if (eop_i) begin
        ok_seed_o <= (seed_next_i == '0);
        ok_zero_o <= (zero_next_i == '0);
      end
    end
  end

  // R6: every receive end byte yields a result strobe
  a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    eop_i |=> res_valid_o);
  // R10: flags only change together with a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> $stable(ok_seed_o) && $stable(ok_zero_o));
endmodule

// File: rtl/crc16_dualseed.sv
module crc16_dualseed
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       seed_i,
  input  logic              dir_tx_i,
  input  logic              tx_zero_seed_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [7:0]        in_data_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_crc_o,
  output logic              out_last_o,
  output logic              res_valid_o,
  output logic              crc_ok_seed_o,
  output logic              crc_ok_zero_o,
  output logic              crc_ok_o
);
  localparam int N_ENG = 2; // engine 0: programmed seed, engine 1: zero seed

  logic                  busy, take, sop_acc, byte_acc, eop_acc;
  logic                  in_pkt_q, dir_q, zsel_q, dir_eff, zsel_eff;
  logic                  tx_acc, tx_eop, rx_eop;
  logic [CRC_W-1:0]      eng_crc  [N_ENG];
  logic [CRC_W-1:0]      eng_next [N_ENG];

  assign take     = in_valid_i && !busy;
  assign sop_acc  = take && in_sop_i;
  assign byte_acc = take && (in_sop_i || in_pkt_q);
  assign eop_acc  = byte_acc && in_eop_i;
  assign dir_eff  = sop_acc ? dir_tx_i       : dir_q;
  assign zsel_eff = sop_acc ? tx_zero_seed_i : zsel_q;
  assign tx_acc   = byte_acc && dir_eff;
  assign tx_eop   = eop_acc && dir_eff;
  assign rx_eop   = eop_acc && !dir_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      dir_q    <= 1'b0;
      zsel_q   <= 1'b0;
    end else begin
      if (sop_acc)      in_pkt_q <= !in_eop_i;
      else if (eop_acc) in_pkt_q <= 1'b0;
      dir_q  <= dir_eff;
      zsel_q <= zsel_eff;
    end
  end

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    logic [CRC_W-1:0] init_w;
    assign init_w = (g == 0) ? seed_i : '0;
    crc16_engine u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_w),
      .load_i     (sop_acc),
      .step_i     (byte_acc),
      .data_i     (in_data_i),
      .crc_o      (eng_crc[g]),
      .crc_next_o (eng_next[g])
    );
  end

  crc16_tx_append u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (tx_acc),
    .eop_i       (tx_eop),
    .data_i      (in_data_i),
    .crc_i       (zsel_q ? eng_crc[1] : eng_crc[0]),
    .busy_o      (busy),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_crc_o   (out_crc_o),
    .out_last_o  (out_last_o)
  );

  crc16_rx_check u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .eop_i       (rx_eop),
    .seed_next_i (eng_next[0]),
    .zero_next_i (eng_next[1]),
    .res_valid_o (res_valid_o),
    .ok_seed_o   (crc_ok_seed_o),
    .ok_zero_o   (crc_ok_zero_o)
  );

  assign crc_ok_o = crc_ok_seed_o || crc_ok_zero_o;

  // R11: transmit output and receive result never coincide
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid_o && res_valid_o));
  // R8: a start strobe while a packet is open keeps the packet open
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_acc && in_pkt_q && !in_eop_i) |=> in_pkt_q);
endmodule

// File: tb/crc16_dualseed_test.sv
module crc16_dualseed_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] seed_i = 0;
  logic dir_tx_i = 0, tx_zero_seed_i = 0, in_valid_i = 0, in_sop_i = 0, in_eop_i = 0;
  logic [7:0] in_data_i = 0;
  logic out_valid_o, out_crc_o, out_last_o, res_valid_o;
  logic crc_ok_seed_o, crc_ok_zero_o, crc_ok_o;
  logic [7:0] out_data_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] pkt [0:63];
  logic [7:0] cap_d [0:63];
  logic cap_c [0:63];
  logic cap_l [0:63];
  int cap_n = 0;
  bit tx_phase = 0, rx_phase = 0;
  int res_in_tx = 0, out_in_rx = 0;

  crc16_dualseed uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    if (out_valid_o && cap_n < 64) begin
      cap_d[cap_n] = out_data_o; cap_c[cap_n] = out_crc_o; cap_l[cap_n] = out_last_o;
      cap_n++;
    end
    if (tx_phase && res_valid_o) res_in_tx++;
    if (rx_phase && out_valid_o) out_in_rx++;
  end

  // Bit-serial model: shift out one bit, fold in the reflected polynomial.
  function automatic logic [15:0] model_crc(input logic [15:0] init, input int n);
    logic [15:0] r = init;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = r[0] ^ pkt[i][b];
        r = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'hA001;
      end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic e, input logic [7:0] d);
    @(negedge clk);
    in_valid_i = v; in_sop_i = s; in_eop_i = e; in_data_i = d;
  endtask

  task automatic run_tx(input int n, input logic [15:0] sd, input bit z, input bit junk);
    logic [15:0] exp;
    bit ok_d = 1, ok_f = 1;
    tx_phase = 1; cap_n = 0;
    seed_i = sd; tx_zero_seed_i = z; dir_tx_i = 1;
    for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
    for (int i = 0; i < n; i++) drive(1, i == 0, i == n-1, pkt[i]);
    if (junk) begin
      drive(1, 0, 0, 8'hEE);
      drive(1, 0, 1, 8'hEF);   // R5: discarded
    end
    drive(0, 0, 0, 8'h00);
    tx_zero_seed_i = ~z; seed_i = ~sd;
    repeat (4) @(negedge clk);
    exp = model_crc(z ? 16'h0000 : sd, n);
    check(cap_n == n + 2, "R5 output count", cap_n, n + 2);
    for (int i = 0; i < n && i < cap_n; i++)
      if (cap_d[i] !== pkt[i] || cap_c[i] || cap_l[i]) ok_d = 0;
    check(ok_d, "R4 pass-through bytes", 0, 0);
    if (cap_n >= n + 2) begin
      ok_f = cap_c[n] && !cap_l[n] && cap_c[n+1] && cap_l[n+1];
      check(ok_f, "R4 crc/last flags", {cap_c[n], cap_l[n], cap_c[n+1], cap_l[n+1]}, 4'b1011);
      check({cap_d[n+1], cap_d[n]} == exp, z ? "R3 zero-seed crc" : "R2 seeded crc",
            {cap_d[n+1], cap_d[n]}, exp);
    end
    tx_phase = 0;
  endtask

  // kind: 0 field from seed, 1 field from zero, 2 random field
  task automatic run_rx(input int n, input logic [15:0] sd, input int kind,
                        input bit restart, input bit noise);
    logic [15:0] fld, cs, cz;
    rx_phase = 1;
    seed_i = sd; dir_tx_i = 0;
    for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
    cs = model_crc(sd, n); cz = model_crc(16'h0000, n);
    fld = (kind == 0) ? cs : (kind == 1) ? cz : 16'($urandom);
    pkt[n] = fld[7:0]; pkt[n+1] = fld[15:8];
    if (noise) begin
      drive(1, 0, 0, 8'h5A);    // R9: stray byte outside a packet
      drive(1, 0, 1, 8'hA5);
    end
    if (restart) begin
      seed_i = ~sd;
      drive(1, 1, 0, 8'h33);    // R8: abandoned partial packet
      drive(1, 0, 0, 8'h44);
      seed_i = sd;
    end
    for (int i = 0; i < n + 2; i++) begin
      drive(1, i == 0, i == n+1, pkt[i]);
      if (noise && i < n + 1) drive(0, 1, 1, 8'($urandom)); // R9: not valid
    end
    drive(0, 0, 0, 8'h00);
    seed_i = 16'($urandom);
    check(res_valid_o === 1'b1, "R6 result strobe", res_valid_o, 1);
    check(crc_ok_seed_o === (fld == cs), restart ? "R8 seed match after restart" : "R6 seed match",
          crc_ok_seed_o, fld == cs);
    check(crc_ok_zero_o === (fld == cz), noise ? "R9 zero match with noise" : "R7 zero match",
          crc_ok_zero_o, fld == cz);
    check(crc_ok_o === ((fld == cs) || (fld == cz)), "R7 combined flag", crc_ok_o,
          (fld == cs) || (fld == cz));
    @(negedge clk);
    check(res_valid_o === 1'b0, "R6 single pulse", res_valid_o, 0);
    rx_phase = 0;
  endtask

  initial begin
    logic [2:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({out_valid_o, res_valid_o, crc_ok_seed_o, crc_ok_zero_o, crc_ok_o} == 0,
          "R1 reset outputs", {out_valid_o, res_valid_o, crc_ok_seed_o, crc_ok_zero_o, crc_ok_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check({out_valid_o, res_valid_o, crc_ok_o} == 0, "R1 after reset", {out_valid_o, res_valid_o, crc_ok_o}, 0);

    // directed corners
    run_tx(1, 16'h1D0F, 0, 0);          // R2 single byte packet
    run_tx(5, 16'hFFFF, 1, 0);          // R3 zero seed chosen
    run_tx(4, 16'hBEEF, 0, 1);          // R5 bytes during append
    run_rx(0, 16'hC0DE, 0, 0, 0);       // R6 empty payload
    run_rx(3, 16'h0000, 0, 0, 0);       // R7 zero seed: both match
    run_rx(6, 16'hABCD, 1, 0, 0);       // R7 only zero match
    run_rx(5, 16'h1357, 0, 1, 0);       // R8 restart
    run_rx(4, 16'h2468, 0, 0, 1);       // R9 noise

    // R10: flags held across a transmit packet
    run_rx(3, 16'h7777, 2, 0, 0);
    held = {crc_ok_seed_o, crc_ok_zero_o, crc_ok_o};
    res_in_tx = 0;
    run_tx(6, 16'h7777, 0, 0);
    check({crc_ok_seed_o, crc_ok_zero_o, crc_ok_o} == held, "R10 flags held",
          {crc_ok_seed_o, crc_ok_zero_o, crc_ok_o}, held);

    // random mix
    for (int k = 0; k < 30; k++) begin
      run_tx(1 + int'($urandom_range(0, 20)), 16'($urandom), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)));
      run_rx(int'($urandom_range(0, 20)), 16'($urandom), int'($urandom_range(0, 2)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    check(res_in_tx == 0, "R11 no result in transmit", res_in_tx, 0);
    check(out_in_rx == 0, "R11 no output in receive", out_in_rx, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule